// File: doc/BRIEF.md
# Multiply-Accumulate Value Conditioner

This block sits beside the multiplier and accumulator bank of a multiply-accumulate unit. It shapes values at three points. The first is the raw 32x32 product, before it reaches an accumulator. The second is a 48-bit accumulator value that has to be brought back into range. The third is an accumulator value being read out to a general register. Products and readouts come in signed integer, unsigned integer and fractional forms. Three configuration bits control the work:

- saturate-on-overflow
- round
- 16-bit / signed selection

The block keeps a small status word. It holds a sticky overflow flag and one overflow bit for each accumulator. Overflows detected during conditioning update these bits. An accumulator copy moves the per-accumulator bit along with the data. Software can overwrite the whole status word with a status-write operation.

Each cycle the block takes one operation. That operation carries an opcode, two operands, an accumulator value, an accumulator index and a source index. The conditioned 64-bit value and the updated status appear one cycle later. The multiplier array and the accumulator storage are outside the block; the caller supplies the accumulator value.

Top module: `mac_cond`

## Requirements
- R1: An operation accepted with `op_valid` high at a clock edge produces `res_valid` high and its result on `res_data` after that edge. `res_valid` is low after a cycle without `op_valid`, and after reset. After reset, `status` is all zero.
- R2: The signed product op (code 0) multiplies the operands as signed 32-bit values. If the product does not fit 40 signed bits, it sets V (status bit 0). In that case, when saturate-on-overflow is set, the result is 2^50 for a positive product and the bitwise complement of 2^50 for a negative one. Otherwise the result is the full product.
- R3: The unsigned product op (code 1) sets V when any of product bits 63..40 is set. With saturate-on-overflow set, the result is then 2^50. Otherwise it is the product truncated to 40 bits.
- R4: The fractional product op (code 2) returns the signed product arithmetically shifted right by 24. With round set, the discarded 24 bits round half to even: add 1 when they exceed 0x800000, and add the kept LSB when they equal 0x800000.
- R5: The signed saturate op (code 3) and the fractional saturate op (code 5) detect overflow when the 64-bit input does not fit 48 signed bits. Overflow sets V and the overflow bit of the indexed accumulator. Saturation clamps by the sign of the full input: the signed op to 0x7FFFFFFF / 0xFFFFFFFF80000000, the fractional op to 0x00007FFFFFFFFFFF / 0xFFFF800000000000. With saturate-on-overflow clear, the result is the low 48 bits sign-extended.
- R6: The unsigned saturate op (code 4) detects overflow when bits 63..48 are nonzero, and then sets V and the indexed accumulator bit. With saturate-on-overflow set, it returns 0 if the input exceeds 2^53 and 2^48-1 otherwise. With it clear, the input is masked to 48 bits.
- R7: The fractional readout op (code 6) has two modes. With the 16-bit bit set, it returns the input shifted right by 24, rounded half to even on the 24 discarded bits. With it clear, it shifts right by 8: with round set, it rounds half to even on those 8 bits; otherwise it truncates. The result is zero-extended into `res_data`.
- R8: The fractional readout with saturate-on-overflow set clamps values that do not fit the signed output width. The clamps are 0x7FFF / 0x8000 in 16-bit mode and 0x7FFFFFFF / 0x80000000 otherwise. Without the bit it keeps the low 16 or 32 bits.
- R9: The signed readout op (code 7) returns the low 32 bits when the input fits 32 signed bits, and otherwise 0x7FFFFFFF or 0x80000000 by sign. The unsigned readout op (code 8) returns the low 32 bits when bits 63..32 are zero, and otherwise 0xFFFFFFFF. Both results are zero-extended.
- R10: V (status bit 0) and the accumulator overflow bits (status bit 4+n for accumulator n) are sticky. Only the status-write op (code 10) changes them to zero. That op loads `status` from `opnd_a` with bits 1..3 forced to zero.
- R11: The copy op (code 9) passes `acc_in` to `res_data`. It sets the overflow bit of accumulator `acc_idx` to the current overflow bit of accumulator `src_idx`.
- R12: Opcodes 11..15 return 0 and leave `status` unchanged. A cycle without `op_valid` leaves `status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code |
| cfg_omc | input | 1 | Saturate-on-overflow |
| cfg_rt | input | 1 | Round enable |
| cfg_su | input | 1 | 16-bit fractional readout select |
| opnd_a | input | 32 | First multiplier operand / status write data |
| opnd_b | input | 32 | Second multiplier operand |
| acc_in | input | 64 | Accumulator value to condition |
| acc_idx | input | 2 | Target accumulator index |
| src_idx | input | 2 | Source accumulator index for copy |
| res_valid | output | 1 | Result valid |
| res_data | output | 64 | Conditioned value |
| status | output | 8 | Sticky V (bit 0) and accumulator overflow bits (bits 4..7) |

## Verification
The bench builds the block with its default parameters: four accumulators, with their overflow bits starting at status bit 4. This places every accumulator bit and the masked gap bits 1..3 inside the 8-bit status word. The bench can then see how a saturate op on index 3, a copy from 3 to 0, and a status write of all ones land. The table covers tie-rounding with odd and even kept bits, both saturation signs, and the 2^53 boundary of unsigned saturation.

// File: rtl/mac_cond_pkg.sv
package mac_cond_pkg;

    localparam int MUL_W = 32;
    localparam int VAL_W = 64;

    typedef enum logic [3:0] {
        OP_MULS  = 4'd0,
        OP_MULU  = 4'd1,
        OP_MULF  = 4'd2,
        OP_SATS  = 4'd3,
        OP_SATU  = 4'd4,
        OP_SATF  = 4'd5,
        OP_RDF   = 4'd6,
        OP_RDS   = 4'd7,
        OP_RDU   = 4'd8,
        OP_MOVE  = 4'd9,
        OP_SETST = 4'd10
    } mac_op_e;

    // kind selectors shared by the datapath submodules
    localparam logic [1:0] K_SIGNED = 2'd0;
    localparam logic [1:0] K_UNSIGN = 2'd1;
    localparam logic [1:0] K_FRAC   = 2'd2;

endpackage

// File: rtl/mac_prod_cond.sv
module mac_prod_cond
    import mac_cond_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [MUL_W-1:0] a,
    input  logic [MUL_W-1:0] b,
    input  logic             omc,
    input  logic             rt,
    output logic [VAL_W-1:0] res,
    output logic             ovf
);
    localparam int FRAC_SH = 24;
    localparam logic [FRAC_SH-1:0] HALF = {1'b1, {(FRAC_SH-1){1'b0}}};
    localparam logic [VAL_W-1:0] FORCE = 64'd1 << 50;

    logic signed [VAL_W-1:0] p_s;
    logic [VAL_W-1:0] p_u;
    logic signed [VAL_W-1:0] q_f;
    logic [FRAC_SH-1:0] rem_f;
    logic inc_f;
    logic fit40;

    always_comb begin
        p_s   = $signed({{MUL_W{a[MUL_W-1]}}, a}) * $signed({{MUL_W{b[MUL_W-1]}}, b});
        p_u   = {{MUL_W{1'b0}}, a} * {{MUL_W{1'b0}}, b};
        q_f   = p_s >>> FRAC_SH;
        rem_f = p_s[FRAC_SH-1:0];
        inc_f = rt && ((rem_f > HALF) || ((rem_f == HALF) && q_f[0]));
        fit40 = (&p_s[VAL_W-1:39]) || !(|p_s[VAL_W-1:39]);
        res   = '0;
        ovf   = 1'b0;
        case (kind)
            K_SIGNED: begin
                ovf = !fit40;
                if (ovf && omc) res = p_s[VAL_W-1] ? ~FORCE : FORCE;
                else            res = p_s;
            end
            K_UNSIGN: begin
                ovf = |p_u[VAL_W-1:40];
                if (ovf && omc) res = FORCE;
                else if (ovf)   res = {24'd0, p_u[39:0]};
                else            res = p_u;
            end
            default: res = q_f + {63'd0, inc_f};
        endcase
    end
endmodule

// File: rtl/mac_acc_sat.sv
module mac_acc_sat
    import mac_cond_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [VAL_W-1:0] acc,
    input  logic             omc,
    output logic [VAL_W-1:0] res,
    output logic             ovf
);
    localparam logic [VAL_W-1:0] S_POS  = 64'h0000_0000_7FFF_FFFF;
    localparam logic [VAL_W-1:0] F_POS  = 64'h0000_7FFF_FFFF_FFFF;
    localparam logic [VAL_W-1:0] U_MAX  = 64'h0000_FFFF_FFFF_FFFF;
    localparam logic [VAL_W-1:0] U_DROP = 64'd1 << 53;

    logic fit48;
    logic [VAL_W-1:0] sext48;

    always_comb begin
        fit48  = (&acc[VAL_W-1:47]) || !(|acc[VAL_W-1:47]);
        sext48 = {{16{acc[47]}}, acc[47:0]};
        res    = sext48;
        ovf    = 1'b0;
        case (kind)
            K_UNSIGN: begin
                ovf = |acc[VAL_W-1:48];
                if (ovf && omc) res = (acc > U_DROP) ? '0 : U_MAX;
                else            res = {16'd0, acc[47:0]};
            end
            K_FRAC: begin
                ovf = !fit48;
                if (ovf && omc) res = acc[VAL_W-1] ? ~F_POS : F_POS;
            end
            default: begin
                ovf = !fit48;
                if (ovf && omc) res = acc[VAL_W-1] ? ~S_POS : S_POS;
            end
        endcase
    end
endmodule

// File: rtl/mac_readout.sv
module mac_readout
    import mac_cond_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [VAL_W-1:0] acc,
    input  logic             su,
    input  logic             rt,
    input  logic             omc,
    output logic [VAL_W-1:0] res
);
    logic signed [VAL_W-1:0] q16, q32, r16, r32;
    logic inc16, inc32, fit16, fit32r, fit32a;

    always_comb begin
        q16    = $signed(acc) >>> 24;
        q32    = $signed(acc) >>> 8;
        inc16  = (acc[23:0] > 24'h800000) || ((acc[23:0] == 24'h800000) && q16[0]);
        inc32  = rt && ((acc[7:0] > 8'h80) || ((acc[7:0] == 8'h80) && q32[0]));
        r16    = q16 + {63'd0, inc16};
        r32    = q32 + {63'd0, inc32};
        fit16  = (&r16[VAL_W-1:15]) || !(|r16[VAL_W-1:15]);
        fit32r = (&r32[VAL_W-1:31]) || !(|r32[VAL_W-1:31]);
        fit32a = (&acc[VAL_W-1:31]) || !(|acc[VAL_W-1:31]);
        case (kind)
            K_FRAC: begin
                if (su) begin
                    if (omc && !fit16) res = r16[VAL_W-1] ? 64'h8000 : 64'h7FFF;
                    else               res = {48'd0, r16[15:0]};
                end else begin
                    if (omc && !fit32r) res = r32[VAL_W-1] ? 64'h8000_0000 : 64'h7FFF_FFFF;
                    else                res = {32'd0, r32[31:0]};
                end
            end
            K_SIGNED: begin
                if (fit32a) res = {32'd0, acc[31:0]};
                else        res = acc[VAL_W-1] ? 64'h8000_0000 : 64'h7FFF_FFFF;
            end
            default: res = (acc[VAL_W-1:32] == '0) ? {32'd0, acc[31:0]} : 64'hFFFF_FFFF;
        endcase
    end
endmodule

// File: rtl/mac_cond.sv
module mac_cond
    import mac_cond_pkg::*;
#(
    parameter int NACC     = 4,
    parameter int PAV_BASE = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        op_valid,
    input  logic [3:0]                  op_code,
    input  logic                        cfg_omc,
    input  logic                        cfg_rt,
    input  logic                        cfg_su,
    input  logic [MUL_W-1:0]            opnd_a,
    input  logic [MUL_W-1:0]            opnd_b,
    input  logic [VAL_W-1:0]            acc_in,
    input  logic [$clog2(NACC)-1:0]     acc_idx,
    input  logic [$clog2(NACC)-1:0]     src_idx,
    output logic                        res_valid,
    output logic [VAL_W-1:0]            res_data,
    output logic [PAV_BASE+NACC-1:0]    status
);
    localparam int STW = PAV_BASE + NACC;

    function automatic logic [STW-1:0] stat_mask();
        logic [STW-1:0] m;
        m = '0;
        m[0] = 1'b1;
        for (int i = 0; i < NACC; i++) m[PAV_BASE+i] = 1'b1;
        return m;
    endfunction
    localparam logic [STW-1:0] ST_MASK = stat_mask();

    typedef struct packed {
        logic             valid;
        mac_op_e          op;
        logic [VAL_W-1:0] res;
        logic [STW-1:0]   stat;
    } state_t;

    state_t st_d, st_q;
    mac_op_e op_in;
    logic [1:0] prod_kind, sat_kind, rd_kind;
    logic [VAL_W-1:0] prod_res, sat_res, rd_res;
    logic prod_ovf, sat_ovf;

    always_comb begin
        op_in     = mac_op_e'(op_code);
        prod_kind = (op_in == OP_MULU) ? K_UNSIGN : (op_in == OP_MULF) ? K_FRAC : K_SIGNED;
        sat_kind  = (op_in == OP_SATU) ? K_UNSIGN : (op_in == OP_SATF) ? K_FRAC : K_SIGNED;
        rd_kind   = (op_in == OP_RDU)  ? K_UNSIGN : (op_in == OP_RDF)  ? K_FRAC : K_SIGNED;
    end

    mac_prod_cond u_prod (
        .kind(prod_kind), .a(opnd_a), .b(opnd_b), .omc(cfg_omc), .rt(cfg_rt),
        .res(prod_res), .ovf(prod_ovf)
    );

    mac_acc_sat u_sat (
        .kind(sat_kind), .acc(acc_in), .omc(cfg_omc), .res(sat_res), .ovf(sat_ovf)
    );

    mac_readout u_rd (
        .kind(rd_kind), .acc(acc_in), .su(cfg_su), .rt(cfg_rt), .omc(cfg_omc), .res(rd_res)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = op_valid;
        if (op_valid) begin
            st_d.op  = op_in;
            st_d.res = '0;
            case (op_in)
                OP_MULS, OP_MULU, OP_MULF: begin
                    st_d.res = prod_res;
                    if (prod_ovf) st_d.stat[0] = 1'b1;
                end
                OP_SATS, OP_SATU, OP_SATF: begin
                    st_d.res = sat_res;
                    if (sat_ovf) begin
                        st_d.stat[0] = 1'b1;
                        st_d.stat[PAV_BASE + int'(acc_idx)] = 1'b1;
                    end
                end
                OP_RDF, OP_RDS, OP_RDU: st_d.res = rd_res;
                OP_MOVE: begin
                    st_d.res = acc_in;
                    st_d.stat[PAV_BASE + int'(acc_idx)] = st_q.stat[PAV_BASE + int'(src_idx)];
                end
                OP_SETST: st_d.stat = opnd_a[STW-1:0] & ST_MASK;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_valid = st_q.valid;
    assign res_data  = st_q.res;
    assign status    = st_q.stat;

    // R1: accepted operation yields a result strobe on the next cycle
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid);

    // R10: sticky overflow flag survives everything but a status write
    p_sticky_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(op_valid && op_code == OP_SETST)) |=> status[0]);

    // R12: idle cycles leave status untouched
    p_idle_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(status));

    // R11: copy transfers the source overflow bit
    p_move_copy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == OP_MOVE) |=>
        status[PAV_BASE + int'($past(acc_idx))] == $past(status[PAV_BASE + int'(src_idx)]));

    // R9: integer readouts never drive the upper word
    p_int_read_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (st_q.op == OP_RDS || st_q.op == OP_RDU)) |-> res_data[63:32] == '0);

    // R6: unsigned saturation result stays within 48 bits
    p_satu_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && st_q.op == OP_SATU) |-> res_data[63:48] == '0);

    // R10: a non-write operation changes at most V plus one accumulator bit
    p_status_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code == OP_SETST) |=> $countones(status ^ $past(status)) <= 2);
endmodule

// File: tb/mac_cond_tb.sv
module mac_cond_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic cfg_omc = 1'b0, cfg_rt = 1'b0, cfg_su = 1'b0;
    logic [31:0] opnd_a = '0, opnd_b = '0;
    logic [63:0] acc_in = '0;
    logic [1:0] acc_idx = '0, src_idx = '0;
    logic res_valid;
    logic [63:0] res_data;
    logic [7:0] status;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mac_cond u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .cfg_omc(cfg_omc), .cfg_rt(cfg_rt), .cfg_su(cfg_su),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .acc_in(acc_in),
        .acc_idx(acc_idx), .src_idx(src_idx),
        .res_valid(res_valid), .res_data(res_data), .status(status)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [2:0]  fl;   // {omc, rt, su}
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] acc;
        logic [1:0]  idx;
        logic [63:0] er;
        logic [7:0]  es;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{4'd0, 3'd0, 32'h10, 32'h20, 64'h0, 2'd0, 64'h200, 8'h00},
        '{4'd0, 3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h0, 2'd0, 64'h3FFFFFFF00000001, 8'h01},
        '{4'd0, 3'd4, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h0, 2'd0, 64'h0004000000000000, 8'h01},
        '{4'd0, 3'd4, 32'h80000000, 32'h7FFFFFFF, 64'h0, 2'd0, 64'hFFFBFFFFFFFFFFFF, 8'h01},
        '{4'd1, 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0, 2'd0, 64'h000000FE00000001, 8'h01},
        '{4'd1, 3'd4, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'h0, 2'd0, 64'h0004000000000000, 8'h01},
        '{4'd1, 3'd0, 32'h100, 32'h100, 64'h0, 2'd0, 64'h10000, 8'h00},
        '{4'd2, 3'd2, 32'h3, 32'h00800000, 64'h0, 2'd0, 64'h2, 8'h00},
        '{4'd2, 3'd0, 32'h3, 32'h00800000, 64'h0, 2'd0, 64'h1, 8'h00},
        '{4'd2, 3'd2, 32'h1, 32'h00800000, 64'h0, 2'd0, 64'h0, 8'h00},
        '{4'd2, 3'd2, 32'hF, 32'h00100000, 64'h0, 2'd0, 64'h1, 8'h00},
        '{4'd2, 3'd0, 32'hFFFFFFFF, 32'h01000000, 64'h0, 2'd0, 64'hFFFFFFFFFFFFFFFF, 8'h00},
        '{4'd3, 3'd4, 32'h0, 32'h0, 64'h0000800000000000, 2'd2, 64'h7FFFFFFF, 8'h41},
        '{4'd3, 3'd0, 32'h0, 32'h0, 64'h0000800000000000, 2'd2, 64'hFFFF800000000000, 8'h41},
        '{4'd3, 3'd4, 32'h0, 32'h0, 64'hFFFFFFFFFFFF1234, 2'd2, 64'hFFFFFFFFFFFF1234, 8'h00},
        '{4'd5, 3'd4, 32'h0, 32'h0, 64'hFFF0000000000000, 2'd1, 64'hFFFF800000000000, 8'h21},
        '{4'd4, 3'd4, 32'h0, 32'h0, 64'h0001000000000000, 2'd3, 64'h0000FFFFFFFFFFFF, 8'h81},
        '{4'd4, 3'd4, 32'h0, 32'h0, 64'h0040000000000000, 2'd0, 64'h0, 8'h11},
        '{4'd4, 3'd0, 32'h0, 32'h0, 64'h0041000000000123, 2'd0, 64'h123, 8'h11},
        '{4'd4, 3'd4, 32'h0, 32'h0, 64'h0000123456789ABC, 2'd0, 64'h0000123456789ABC, 8'h00},
        '{4'd6, 3'd1, 32'h0, 32'h0, 64'h0000001234800000, 2'd0, 64'h1234, 8'h00},
        '{4'd6, 3'd1, 32'h0, 32'h0, 64'h0000001235800000, 2'd0, 64'h1236, 8'h00},
        '{4'd6, 3'd5, 32'h0, 32'h0, 64'h0000008000000000, 2'd0, 64'h7FFF, 8'h00},
        '{4'd6, 3'd5, 32'h0, 32'h0, 64'hFFFFFF0000000000, 2'd0, 64'h8000, 8'h00},
        '{4'd6, 3'd2, 32'h0, 32'h0, 64'h0000000012345681, 2'd0, 64'h123457, 8'h00},
        '{4'd6, 3'd0, 32'h0, 32'h0, 64'h0000000012345681, 2'd0, 64'h123456, 8'h00},
        '{4'd6, 3'd6, 32'h0, 32'h0, 64'h0000008000000000, 2'd0, 64'h7FFFFFFF, 8'h00},
        '{4'd6, 3'd0, 32'h0, 32'h0, 64'hFFFFFFFF00000000, 2'd0, 64'hFF000000, 8'h00},
        '{4'd7, 3'd0, 32'h0, 32'h0, 64'hFFFFFFFFFFFFFFFE, 2'd0, 64'hFFFFFFFE, 8'h00},
        '{4'd7, 3'd0, 32'h0, 32'h0, 64'h0000000100000000, 2'd0, 64'h7FFFFFFF, 8'h00},
        '{4'd7, 3'd0, 32'h0, 32'h0, 64'hFFFFFFFE00000000, 2'd0, 64'h80000000, 8'h00},
        '{4'd8, 3'd0, 32'h0, 32'h0, 64'h00000000DEADBEEF, 2'd0, 64'hDEADBEEF, 8'h00},
        '{4'd8, 3'd0, 32'h0, 32'h0, 64'h0000000100000000, 2'd0, 64'hFFFFFFFF, 8'h00}
    };

    function automatic string tag_of(input logic [3:0] op, input bit rd_sat);
        case (op)
            4'd0: return "R2";
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3, 4'd5: return "R5";
            4'd4: return "R6";
            4'd6: return rd_sat ? "R8" : "R7";
            4'd7, 4'd8: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_op(input logic [3:0] op, input logic [2:0] fl,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [63:0] acc, input logic [1:0] idx,
                         input logic [1:0] src);
        @(negedge clk);
        op_valid = 1'b1; op_code = op;
        {cfg_omc, cfg_rt, cfg_su} = fl;
        opnd_a = a; opnd_b = b; acc_in = acc; acc_idx = idx; src_idx = src;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "reset valid", {63'd0, res_valid}, 64'd0);
        check("R1", "reset status", {56'd0, status}, 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            do_op(4'd10, 3'd0, 32'h0, 32'h0, 64'h0, 2'd0, 2'd0);
            do_op(TBL[i].op, TBL[i].fl, TBL[i].a, TBL[i].b, TBL[i].acc, TBL[i].idx, 2'd0);
            check(tag_of(TBL[i].op, TBL[i].fl[2]), $sformatf("vec %0d result", i), res_data, TBL[i].er);
            check(tag_of(TBL[i].op, TBL[i].fl[2]), $sformatf("vec %0d status", i), {56'd0, status}, {56'd0, TBL[i].es});
            check("R1", $sformatf("vec %0d valid", i), {63'd0, res_valid}, 64'd1);
        end

        // R1: no op -> no strobe
        @(negedge clk);
        check("R1", "idle valid", {63'd0, res_valid}, 64'd0);

        // R10: V sticky across a clean product
        do_op(4'd10, 3'd0, 32'h0, 32'h0, 64'h0, 2'd0, 2'd0);
        do_op(4'd0, 3'd0, 32'h7FFFFFFF, 32'h7FFFFFFF, 64'h0, 2'd0, 2'd0);
        do_op(4'd0, 3'd0, 32'h2, 32'h3, 64'h0, 2'd0, 2'd0);
        check("R10", "sticky V", {56'd0, status}, 64'h01);
        check("R2", "clean product after overflow", res_data, 64'h6);

        // R11: copy overflow bit from acc 3 to acc 0, then clear acc 3 from acc 1
        do_op(4'd10, 3'd0, 32'h0, 32'h0, 64'h0, 2'd0, 2'd0);
        do_op(4'd4, 3'd0, 32'h0, 32'h0, 64'h0001000000000000, 2'd3, 2'd0);
        do_op(4'd9, 3'd0, 32'h0, 32'h0, 64'h0123456789ABCDEF, 2'd0, 2'd3);
        check("R11", "copy sets bit", {56'd0, status}, 64'h91);
        check("R11", "copy data", res_data, 64'h0123456789ABCDEF);
        do_op(4'd9, 3'd0, 32'h0, 32'h0, 64'h0, 2'd3, 2'd1);
        check("R11", "copy clears bit", {56'd0, status}, 64'h11);

        // R10: status write masks gap bits
        do_op(4'd10, 3'd0, 32'hFFFFFFFF, 32'h0, 64'h0, 2'd0, 2'd0);
        check("R10", "status write", {56'd0, status}, 64'hF1);

        // R12: unused opcode -> zero result, status unchanged
        do_op(4'd13, 3'd7, 32'hFFFFFFFF, 32'hFFFFFFFF, 64'hFFFFFFFFFFFFFFFF, 2'd0, 2'd0);
        check("R12", "unused op result", res_data, 64'h0);
        check("R12", "unused op status", {56'd0, status}, 64'hF1);

        // R12: idle cycle with busy inputs leaves status unchanged
        @(negedge clk);
        op_code = 4'd10; opnd_a = 32'h0;
        @(negedge clk);
        check("R12", "idle status", {56'd0, status}, 64'hF1);

        finish_run();
    end
endmodule